// File: doc/BRIEF.md
# Shadow Stack Exception Record Pusher

This block carries out a privileged "push exception record" operation on a hardware shadow stack. A single-cycle `start` pulse captures a snapshot of its inputs. These are the register field of the encoding, the stack-enable flag, the current privilege level, the exception-lock state bit, one lock-enable bit for each level, and the link, saved-status, exception-return and stack-pointer values.

In the cycle after capture the block checks access rights and the encoding. If the operation may go ahead, it writes a four-entry record downward from the stack pointer through a valid/ready write port. The last entry is a fixed marker token. When all four writes are done, the block returns the new stack pointer and a request to clear the exception-lock bit.

Every accepted start ends in exactly one one-cycle result pulse. That pulse is one of: completion, lock trap, undefined encoding, or alignment fault.

Top module: `ssx_pusher`

## Requirements
- R1: When the captured lock state bit is 0 and bit `cur_lvl` of `lock_en` is 1, `trap` pulses. No write is issued, and `sp_we` and `lock_clr` stay low. This check takes priority over all other checks.
- R2: When R1 does not apply and `reg_field` is not all ones (31), `undef` pulses and no write is issued.
- R3: When R1 and R2 do not apply and `stk_en` is 0, `done` pulses with no write, and `sp_we` and `lock_clr` stay low.
- R4: When R1 to R3 do not apply and `sp_in[2:0]` is not zero, `align_fault` pulses with no write, and `sp_we` and `lock_clr` stay low.
- R5: Otherwise, four writes are issued in order: the link value at SP-8, the saved-status value at SP-16, and the return value at SP-24.
- R6: The fourth write stores the token 9 (binary 1001), zero-extended to 64 bits, at SP-32.
- R7: Every write address is 8-byte aligned. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R8: In the cycle after the fourth write is accepted, `done`, `sp_we` and `lock_clr` pulse together, with `sp_out` equal to SP-32.
- R9: Each accepted start yields exactly one of `done`, `trap`, `undef` or `align_fault`, high for one cycle. For outcomes that issue no write, this pulse comes two clock edges after the edge that samples `start`. A start that arrives while the block is busy is ignored.
- R10: After reset, all outputs that carry a pulse or a valid signal are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| reg_field | input | 5 | Register field of the encoding |
| stk_en | input | 1 | Shadow stack enabled |
| cur_lvl | input | 2 | Current privilege level |
| lock_st | input | 1 | Exception-lock state bit |
| lock_en | input | 4 | Lock-enable bit, one per level |
| link_val | input | 64 | Link register value |
| sts_val | input | 64 | Saved status value for the current level |
| ret_val | input | 64 | Exception return address for the current level |
| sp_in | input | 64 | Shadow stack pointer for the current level |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 64 | Write byte address |
| wr_data | output | 64 | Write data |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_out | output | 64 | New stack pointer value |
| lock_clr | output | 1 | Clear the exception-lock state bit |
| done | output | 1 | Operation completed |
| trap | output | 1 | Lock trap |
| undef | output | 1 | Undefined encoding |
| align_fault | output | 1 | Misaligned stack pointer |

## Verification
The bench builds the block with its default parameters: four levels, a 5-bit register field and 64-bit data. At that size it can sweep every level against every lock-enable mask and both lock-state values. It combines these with four register-field values, both enable settings and three stack-pointer alignments. Together these cover every branch of the priority chain and every outcome at every level. The write port is stalled in a fixed pseudo-random pattern, so holding during a stall and the ordering of the record are exercised on every successful push. A second start during the busy phase is injected in every operation.

// File: rtl/ssx_pusher.sv
module ssx_pusher #(
  parameter int DW    = 64,
  parameter int NLVL  = 4,
  parameter int RFW   = 5,
  parameter int TOKEN = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [RFW-1:0]          reg_field,
  input  logic                    stk_en,
  input  logic [$clog2(NLVL)-1:0] cur_lvl,
  input  logic                    lock_st,
  input  logic [NLVL-1:0]         lock_en,
  input  logic [DW-1:0]           link_val,
  input  logic [DW-1:0]           sts_val,
  input  logic [DW-1:0]           ret_val,
  input  logic [DW-1:0]           sp_in,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [DW-1:0]           wr_addr,
  output logic [DW-1:0]           wr_data,
  output logic                    sp_we,
  output logic [DW-1:0]           sp_out,
  output logic                    lock_clr,
  output logic                    done,
  output logic                    trap,
  output logic                    undef,
  output logic                    align_fault
);
  localparam int LW     = $clog2(NLVL);
  localparam int ABYTES = DW / 8;
  localparam int ALO    = $clog2(ABYTES);
  localparam int NREC   = 4;
  localparam int IW     = $clog2(NREC);

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_WR} st_t;
  st_t st;

  logic [RFW-1:0]  field_q;
  logic            en_q, lock_q;
  logic [LW-1:0]   lvl_q;
  logic [NLVL-1:0] lken_q;
  logic [DW-1:0]   link_q, sts_q, ret_q, sp_q;
  logic [IW-1:0]   idx;
  logic            done_q, trap_q, undef_q, algn_q, fin_q;

  wire lock_hit = !lock_q && lken_q[lvl_q];
  wire bad_enc  = field_q != {RFW{1'b1}};
  wire misal    = |sp_q[ALO-1:0];
  wire accept   = wr_valid && wr_ready;
  wire last     = idx == IW'(NREC - 1);

  assign wr_valid    = st == S_WR;
  assign wr_addr     = sp_q - DW'((32'(idx) + 1) * ABYTES);
  assign sp_out      = sp_q - DW'(NREC * ABYTES);
  assign sp_we       = fin_q;
  assign lock_clr    = fin_q;
  assign done        = done_q;
  assign trap        = trap_q;
  assign undef       = undef_q;
  assign align_fault = algn_q;

  always_comb begin
    case (idx)
      2'd0:    wr_data = link_q;
      2'd1:    wr_data = sts_q;
      2'd2:    wr_data = ret_q;
      default: wr_data = DW'(TOKEN);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      idx <= '0;
      {done_q, trap_q, undef_q, algn_q, fin_q} <= '0;
      field_q <= '0; en_q <= 1'b0; lock_q <= 1'b0; lvl_q <= '0; lken_q <= '0;
      link_q <= '0; sts_q <= '0; ret_q <= '0; sp_q <= '0;
    end else begin
      {done_q, trap_q, undef_q, algn_q, fin_q} <= '0;
      case (st)
        S_IDLE: if (start) begin
          field_q <= reg_field; en_q <= stk_en; lock_q <= lock_st;
          lvl_q <= cur_lvl; lken_q <= lock_en;
          link_q <= link_val; sts_q <= sts_val; ret_q <= ret_val; sp_q <= sp_in;
          idx <= '0;
          st  <= S_CHK;
        end
        S_CHK: begin
          st <= S_IDLE;
          if (lock_hit)     trap_q  <= 1'b1;
          else if (bad_enc) undef_q <= 1'b1;
          else if (!en_q)   done_q  <= 1'b1;
          else if (misal)   algn_q  <= 1'b1;
          else              st      <= S_WR;
        end
        S_WR: if (accept) begin
          if (last) begin
            st <= S_IDLE;
            done_q <= 1'b1;
            fin_q  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssx_pusher_chk.sv
module ssx_pusher_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [DW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          sp_we,
  input logic          lock_clr,
  input logic          done,
  input logic          trap,
  input logic          undef,
  input logic          align_fault
);
  assert_one_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, trap, undef, align_fault}));
  assert_pulse_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || trap || undef || align_fault) |=> !(done || trap || undef || align_fault));
  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  assert_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[2:0] == 3'd0));
  assert_fault_no_update_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (trap || undef || align_fault) |-> (!sp_we && !lock_clr));
  assert_update_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we || lock_clr) |-> (done && sp_we && lock_clr));
  assert_no_write_at_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || trap || undef || align_fault) |-> !wr_valid);
endmodule

bind ssx_pusher ssx_pusher_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .sp_we(sp_we), .lock_clr(lock_clr),
  .done(done), .trap(trap), .undef(undef), .align_fault(align_fault)
);

// File: tb/sim_ssx_pusher.sv
`timescale 1ns/1ps
module sim_ssx_pusher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  reg_field = '0;
  logic        stk_en = 1'b0;
  logic [1:0]  cur_lvl = '0;
  logic        lock_st = 1'b0;
  logic [3:0]  lock_en = '0;
  logic [63:0] link_val = '0, sts_val = '0, ret_val = '0, sp_in = '0;
  logic        wr_valid, wr_ready = 1'b0;
  logic [63:0] wr_addr, wr_data, sp_out;
  logic        sp_we, lock_clr, done, trap, undef, align_fault;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, rctr = 0;
  bit timed_out = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ssx_pusher u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] lv, input bit ls, input logic [3:0] le,
                        input logic [4:0] fld, input bit en, input logic [63:0] sp);
    logic [63:0] lk, ss, rt, exp_d;
    int exp_kind, nw, npulse, k, pulse_at, post;
    bit prev_stall;
    logic [63:0] prev_a, prev_d;
    lk = {32'hA5A5_0000, 24'd0, lv, ls, fld, 1'b0} ^ sp;
    ss = 64'h0000_0000_0300_03C5 + {60'd0, le};
    rt = 64'hFFFF_8000_1234_0000 + sp;
    // 0 trap, 1 undef, 2 noop done, 3 align, 4 success
    if (!ls && le[lv])     exp_kind = 0;
    else if (fld != 5'd31) exp_kind = 1;
    else if (!en)          exp_kind = 2;
    else if (sp[2:0] != 0) exp_kind = 3;
    else                   exp_kind = 4;
    @(negedge clk);
    reg_field = fld; stk_en = en; cur_lvl = lv; lock_st = ls; lock_en = le;
    link_val = lk; sts_val = ss; ret_val = rt; sp_in = sp; start = 1'b1;
    @(negedge clk);
    // busy start with altered inputs must be ignored (R9)
    sp_in = ~sp; link_val = ~lk; reg_field = 5'd31; lock_en = 4'd0; stk_en = 1'b1;
    nw = 0; npulse = 0; pulse_at = -1; post = 0; prev_stall = 0;
    prev_a = '0; prev_d = '0;
    for (k = 1; k < 60; k++) begin
      if (k == 2) start = 1'b0;
      if (k == 4 && exp_kind == 4) start = 1'b1;
      if (k == 5) start = 1'b0;
      wr_ready = ((rctr * 5) % 7) < 4;
      rctr++;
      #1;
      if (prev_stall)
        chk(wr_valid && wr_addr == prev_a && wr_data == prev_d, "R7 hold", wr_addr, prev_a);
      if (wr_valid) chk(wr_addr[2:0] == 3'd0, "R7 align", wr_addr, {wr_addr[63:3], 3'd0});
      if (wr_valid && wr_ready) begin
        case (nw)
          0: exp_d = lk;
          1: exp_d = ss;
          2: exp_d = rt;
          default: exp_d = 64'd9;
        endcase
        if (nw < 3) chk(wr_addr == sp - 64'(8 * (nw + 1)) && wr_data == exp_d, "R5 record", wr_data, exp_d);
        else        chk(wr_addr == sp - 64'd32 && wr_data == 64'd9, "R6 token", wr_data, 64'd9);
        nw++;
      end
      prev_stall = wr_valid && !wr_ready;
      prev_a = wr_addr; prev_d = wr_data;
      if (done || trap || undef || align_fault) begin
        npulse++;
        if (pulse_at < 0) pulse_at = k;
        case (exp_kind)
          0: chk(trap, "R1 trap", {60'd0, done, trap, undef, align_fault}, 64'h4);
          1: chk(undef, "R2 undef", {60'd0, done, trap, undef, align_fault}, 64'h2);
          2: chk(done && !sp_we && !lock_clr, "R3 noop", {62'd0, sp_we, done}, 64'h1);
          3: chk(align_fault && !sp_we && !lock_clr, "R4 align", {60'd0, done, trap, undef, align_fault}, 64'h1);
          default: chk(done && sp_we && lock_clr && sp_out == sp - 64'd32, "R8 finish", sp_out, sp - 64'd32);
        endcase
      end
      if (pulse_at >= 0) post++;
      if (post > 3) break;
      @(negedge clk);
    end
    start = 1'b0;
    chk(npulse == 1, "R9 one result", 64'(npulse), 64'd1);
    if (exp_kind != 4) begin
      chk(pulse_at == 2, "R9 timing", 64'(pulse_at), 64'd2);
      chk(nw == 0, exp_kind == 0 ? "R1 no write" : exp_kind == 1 ? "R2 no write" :
                   exp_kind == 2 ? "R3 no write" : "R4 no write", 64'(nw), 64'd0);
    end else begin
      chk(nw == 4, "R5 write count", 64'(nw), 64'd4);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!wr_valid && !done && !trap && !undef && !align_fault && !sp_we && !lock_clr,
            "R10 reset", {57'd0, wr_valid, done, trap, undef, align_fault, sp_we, lock_clr}, 64'd0);
        for (int lv = 0; lv < 4; lv++)
          for (int ls = 0; ls < 2; ls++)
            for (int le = 0; le < 16; le++)
              for (int fi = 0; fi < 4; fi++)
                for (int en = 0; en < 2; en++)
                  for (int sa = 0; sa < 3; sa++) begin
                    logic [4:0] f;
                    logic [63:0] sp;
                    f  = (fi == 0) ? 5'd31 : (fi == 1) ? 5'd0 : (fi == 2) ? 5'd30 : 5'd15;
                    sp = 64'h0000_7FFF_FFF0_1000 + 64'(lv * 256 + le * 16) +
                         ((sa == 0) ? 64'd0 : (sa == 1) ? 64'd3 : 64'd4);
                    run_op(2'(lv), 1'(ls), 4'(le), f, 1'(en), sp);
                  end
      end
      begin
        wait (cyc > 190000);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule